// File: doc/BRIEF.md
# Source-Synchronous Parallel Transmit Channel

This block takes words from a ready/valid stream and sends them out over a parallel bus that carries 8 to 16 bits. It produces its own forwarded I/O clock by dividing the fast transmit clock that it runs on. Two qualifiers go with every word. An enable output marks the bus cycles that carry data. A start output marks the first word of each line, and the line length comes from a configuration input. The receiver can pause the flow at any time with a wait input. A paused word is held and sent later. It is never lost.

In single data rate operation the channel sends one word per I/O clock period. A configuration bit chooses which I/O clock edge the words change on, and the receiver captures on the opposite edge. In double data rate operation the channel sends one word per half period. Each word changes in the middle of the half period, so it is stable across the edge where it is captured. Double data rate needs at least two transmit-clock cycles per half period. For that reason, asking for it with the divider at zero is treated as a configuration error, and the channel then stays silent.

Top module: `srcsync_tx_chan`

## Requirements
- R1: While reset is asserted, the following outputs are all low: io_clk_o, io_enable_o, io_start_o, io_data_o and cfg_err_o.
- R2: io_clk_o has a period of exactly 2×(cfg_div_i+1) transmit-clock cycles. It is high for cfg_div_i+1 cycles and low for cfg_div_i+1 cycles.
- R3: With cfg_ddr_i=0, at most one word is launched per I/O clock period. io_data_o and io_enable_o change only in a cycle where io_clk_o moves to the level cfg_inv_i. So with cfg_inv_i=0 they change on the falling edge and are captured on the rising edge, and with cfg_inv_i=1 the other way round.
- R4: With cfg_ddr_i=1 and cfg_div_i≥1, one word is launched per I/O half period. io_data_o and io_enable_o never change in a cycle where io_clk_o changes, so both edges are capture edges.
- R5: A line is cfg_len_i+1 words. io_start_o is high with the first word of every line and low otherwise. The word count within a line is kept across idle gaps and waits.
- R6: io_enable_o is high exactly while an accepted word is presented. When no word is available, io_enable_o and io_start_o are low and io_data_o keeps its last value.
- R7: A word is accepted at a clock edge where s_valid_i and s_ready_o are both high. Accepted words appear on the bus in order, each exactly once.
- R8: The effective word width is cfg_width_i limited to the range 8..16. Bus bits at or above the effective width are driven 0.
- R9: io_wait_i passes through a two-flop synchronizer. At the next launch point after it is seen, the channel stops presenting words: io_enable_o goes low and io_data_o is held. No word is dropped, and sending resumes after the wait is released.
- R10: With cfg_ddr_i=1 and cfg_div_i=0, cfg_err_o goes high one cycle later and io_enable_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast transmit clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_div_i | input | 4 | Divider setting: half period is cfg_div_i+1 cycles |
| cfg_ddr_i | input | 1 | 1 = double data rate, 0 = single data rate |
| cfg_inv_i | input | 1 | Single data rate launch edge: 0 falling, 1 rising |
| cfg_width_i | input | 5 | Word width in bits, limited to 8..16 |
| cfg_len_i | input | 8 | Line length minus one, in words |
| s_valid_i | input | 1 | Input word valid |
| s_data_i | input | 16 | Input word |
| s_ready_o | output | 1 | Channel can take a word |
| io_wait_i | input | 1 | Asynchronous pause request from the receiver |
| io_clk_o | output | 1 | Forwarded I/O clock |
| io_data_o | output | 16 | Parallel data bus |
| io_start_o | output | 1 | First word of a line |
| io_enable_o | output | 1 | Bus carries a valid word |
| cfg_err_o | output | 1 | Double data rate requested with divider 0 |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- the I/O clock toggles only when its counter wraps;
- in single data rate, launches line up with the chosen edge, and in double data rate they stay off the edges;
- start is always qualified by enable;
- bits above the width are zero;
- wait and the error state both suppress enable.

Only the bench scenarios can show the end-to-end properties, and they do so by capturing words the way a receiver would, on the correct edges:
- the I/O clock period;
- in-order, loss-free delivery across random valid gaps and long waits;
- line counting for start;
- holding the last data value when idle.

// File: rtl/txc_pkg.sv
package txc_pkg;

    typedef enum logic [1:0] {
        LM_SDR_FALL = 2'd0,  // words change on falling edge, captured on rising
        LM_SDR_RISE = 2'd1,  // words change on rising edge, captured on falling
        LM_DDR      = 2'd2,  // words change mid half-period
        LM_BLOCKED  = 2'd3   // illegal setting, nothing is sent
    } launch_mode_e;

    function automatic launch_mode_e pick_mode(input logic ddr, input logic inv,
                                               input logic div_zero);
        if (ddr && div_zero) return LM_BLOCKED;
        if (ddr)             return LM_DDR;
        if (inv)             return LM_SDR_RISE;
        return LM_SDR_FALL;
    endfunction

endpackage

// File: rtl/txc_sync.sv
module txc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/txc_clkgen.sv
module txc_clkgen
    import txc_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  launch_mode_e     mode_i,
    output logic             io_clk_o,
    output logic             slot_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } gen_t;

    gen_t g_d, g_q;
    logic wrap;
    logic [DIV_W-1:0] mid;

    assign mid  = div_i >> 1;
    assign wrap = (g_q.cnt >= div_i);

    always_comb begin
        g_d = g_q;
        if (wrap) begin
            g_d.cnt = '0;
            g_d.lvl = ~g_q.lvl;
        end else begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_comb begin
        unique case (mode_i)
            LM_SDR_FALL: slot_o = wrap && g_q.lvl;
            LM_SDR_RISE: slot_o = wrap && !g_q.lvl;
            LM_DDR:      slot_o = (g_q.cnt == mid);
            default:     slot_o = wrap;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) g_q <= '0;
        else         g_q <= g_d;
    end

    assign io_clk_o = g_q.lvl;

    AST_CLK_EDGE_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(g_q.lvl) |-> (g_q.cnt == '0) && ($past(g_q.cnt) >= $past(div_i))); // R2

    AST_COUNT_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(g_q.lvl) && $past(rst_ni) |-> g_q.cnt == $past(g_q.cnt) + 1'b1); // R2

endmodule

// File: rtl/txc_lane_fmt.sv
module txc_lane_fmt #(
    parameter int MAX_W = 16,
    parameter int MIN_W = 8,
    parameter int WW    = $clog2(MAX_W + 1)
) (
    input  logic [WW-1:0]    width_i,
    input  logic [MAX_W-1:0] word_i,
    output logic [MAX_W-1:0] word_o,
    output logic [MAX_W-1:0] mask_o
);
    logic [WW-1:0] eff_w;

    always_comb begin
        if (width_i < WW'(MIN_W))      eff_w = WW'(MIN_W);
        else if (width_i > WW'(MAX_W)) eff_w = WW'(MAX_W);
        else                           eff_w = width_i;
    end

    for (genvar b = 0; b < MAX_W; b++) begin : g_lane
        assign mask_o[b] = (WW'(b) < eff_w);
        assign word_o[b] = word_i[b] & mask_o[b];
    end

endmodule

// File: rtl/srcsync_tx_chan.sv
module srcsync_tx_chan
    import txc_pkg::*;
#(
    parameter int MAX_W       = 16,
    parameter int DIV_W       = 4,
    parameter int LEN_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int WW         = $clog2(MAX_W + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] cfg_div_i,
    input  logic             cfg_ddr_i,
    input  logic             cfg_inv_i,
    input  logic [WW-1:0]    cfg_width_i,
    input  logic [LEN_W-1:0] cfg_len_i,
    input  logic             s_valid_i,
    input  logic [MAX_W-1:0] s_data_i,
    output logic             s_ready_o,
    input  logic             io_wait_i,
    output logic             io_clk_o,
    output logic [MAX_W-1:0] io_data_o,
    output logic             io_start_o,
    output logic             io_enable_o,
    output logic             cfg_err_o
);
    typedef struct packed {
        logic             hold_vld;
        logic [MAX_W-1:0] hold_data;
        logic [MAX_W-1:0] data;
        logic             en;
        logic             start;
        logic [LEN_W-1:0] pos;
        logic             err;
    } seq_t;

    seq_t s_d, s_q;

    launch_mode_e     mode;
    logic             slot;
    logic             wait_s;
    logic [MAX_W-1:0] fmt_word;
    logic [MAX_W-1:0] lane_mask;
    logic             blocked;

    assign mode    = pick_mode(cfg_ddr_i, cfg_inv_i, cfg_div_i == '0);
    assign blocked = (mode == LM_BLOCKED);

    txc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .div_i    (cfg_div_i),
        .mode_i   (mode),
        .io_clk_o (io_clk_o),
        .slot_o   (slot)
    );

    txc_sync #(.STAGES(SYNC_STAGES)) u_wait_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (io_wait_i),
        .sync_o  (wait_s)
    );

    txc_lane_fmt #(.MAX_W(MAX_W), .MIN_W(8), .WW(WW)) u_fmt (
        .width_i (cfg_width_i),
        .word_i  (s_q.hold_data),
        .word_o  (fmt_word),
        .mask_o  (lane_mask)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = blocked;
        if (slot) begin
            if (blocked || wait_s || !s_q.hold_vld) begin
                s_d.en    = 1'b0;
                s_d.start = 1'b0;
            end else begin
                s_d.data     = fmt_word;
                s_d.en       = 1'b1;
                s_d.start    = (s_q.pos == '0);
                s_d.pos      = (s_q.pos >= cfg_len_i) ? '0 : s_q.pos + 1'b1;
                s_d.hold_vld = 1'b0;
            end
        end
        if (s_valid_i && !s_q.hold_vld) begin
            s_d.hold_vld  = 1'b1;
            s_d.hold_data = s_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign s_ready_o   = !s_q.hold_vld;
    assign io_data_o   = s_q.data;
    assign io_enable_o = s_q.en;
    assign io_start_o  = s_q.start;
    assign cfg_err_o   = s_q.err;

    AST_START_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        io_start_o |-> io_enable_o); // R5

    AST_SDR_LAUNCH_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(slot) && ($past(mode) == LM_SDR_FALL || $past(mode) == LM_SDR_RISE)
        |-> io_clk_o == $past(cfg_inv_i) && !$stable(io_clk_o)); // R3

    AST_DDR_OFF_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == LM_DDR) && $past(mode == LM_DDR) && !$stable(io_data_o) |-> $stable(io_clk_o)); // R4

    AST_DATA_ONLY_AT_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(slot) |-> $stable(io_data_o) && $stable(io_enable_o)); // R6

    AST_WIDTH_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        io_enable_o && $stable(cfg_width_i) && $past(io_enable_o) |-> (io_data_o & ~lane_mask) == '0); // R8

    AST_WAIT_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(slot && wait_s) |-> !io_enable_o && $stable(io_data_o)); // R9

    AST_ERR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(slot && blocked) |-> !io_enable_o); // R10

    AST_ACCEPT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_valid_i && s_ready_o |=> !s_ready_o); // R7

endmodule

// File: tb/srcsync_tx_chan_tb.sv
module srcsync_tx_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_div = '0;
    logic        cfg_ddr = 1'b0;
    logic        cfg_inv = 1'b0;
    logic [4:0]  cfg_width = 5'd16;
    logic [7:0]  cfg_len = '0;
    logic        s_valid = 1'b0;
    logic [15:0] s_data = '0;
    logic        s_ready;
    logic        io_wait = 1'b0;
    logic        io_clk, io_start, io_en, cfg_err;
    logic [15:0] io_data;

    always #5 clk = ~clk;

    srcsync_tx_chan u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_div_i(cfg_div), .cfg_ddr_i(cfg_ddr),
        .cfg_inv_i(cfg_inv), .cfg_width_i(cfg_width), .cfg_len_i(cfg_len),
        .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
        .io_wait_i(io_wait), .io_clk_o(io_clk), .io_data_o(io_data),
        .io_start_o(io_start), .io_enable_o(io_en), .cfg_err_o(cfg_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] sb[$];
    int gen_left = 0;
    int vpct = 100;
    bit mon_on = 0;
    bit first = 1;
    bit err_case = 0;
    bit in_wait = 0;
    int pos = 0;
    int cyc = 0;
    int total = 0;
    int last_rise = -1;
    logic prev_clk;
    logic prev_en;
    logic [15:0] prev_data;
    logic [15:0] last_exp = '0;
    bit done = 0;

    function automatic int eff_w(input logic [4:0] w);
        if (w < 5'd8)  return 8;
        if (w > 5'd16) return 16;
        return int'(w);
    endfunction

    function automatic logic [15:0] masked(input logic [15:0] d, input logic [4:0] w);
        return d & 16'((32'd1 << eff_w(w)) - 1);
    endfunction

    function automatic int period(input logic [3:0] d);
        return 2 * (int'(d) + 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor, scoreboard and stream driver, all at the falling clock edge
    always @(negedge clk) begin
        total++;
        if (total > 190000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", total, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
        if (mon_on) begin
            cyc++;
            if (first) begin
                first = 0;
            end else begin
                logic clk_chg;
                logic dat_chg;
                logic cap;
                clk_chg = (io_clk != prev_clk);
                dat_chg = (io_data != prev_data) || (io_en != prev_en);
                if (clk_chg && io_clk) begin
                    if (last_rise >= 0) chk("R2 io clock period", cyc - last_rise, period(cfg_div));
                    last_rise = cyc;
                end
                if (err_case) begin
                    if (io_en) chk("R10 enable while config error", io_en, 0);
                end else begin
                    if (!cfg_ddr && dat_chg)
                        chk("R3 sdr launch on chosen edge", {clk_chg, io_clk}, {1'b1, cfg_inv});
                    if (cfg_ddr && dat_chg)
                        chk("R4 ddr launch off clock edges", clk_chg, 0);
                    cap = clk_chg && (cfg_ddr || (io_clk == !cfg_inv));
                    if (cap) begin
                        if (in_wait) chk("R9 enable during wait", io_en, 0);
                        if (io_en) begin
                            if (sb.size() == 0) begin
                                chk("R7 word without accepted input", 1, 0);
                            end else begin
                                logic [15:0] e;
                                e = masked(sb.pop_front(), cfg_width);
                                chk("R7 R8 word content", io_data, e);
                                chk("R5 start strobe", io_start, (pos == 0));
                                last_exp = e;
                                pos = (pos >= int'(cfg_len)) ? 0 : pos + 1;
                            end
                        end else if (io_start) begin
                            chk("R6 start without enable", io_start, 0);
                        end
                    end
                end
            end
            prev_clk = io_clk;
            prev_data = io_data;
            prev_en = io_en;
            if (s_valid && s_ready) begin
                sb.push_back(s_data);
                gen_left--;
                s_valid = 1'b0;
            end
            if (!s_valid && gen_left > 0 && $urandom_range(99) < vpct) begin
                s_valid = 1'b1;
                s_data  = 16'($urandom);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_case(input logic [3:0] div, input logic ddr, input logic inv,
                            input logic [4:0] w, input logic [7:0] len, input int nw,
                            input int pct, input bit do_wait);
        int p;
        int t;
        logic [15:0] snap;
        mon_on = 0;
        s_valid = 1'b0;
        io_wait = 1'b0;
        rst_n = 1'b0;
        cfg_div = div; cfg_ddr = ddr; cfg_inv = inv; cfg_width = w; cfg_len = len;
        cycles(4);
        chk("R1 reset state", {io_clk, io_en, io_start, cfg_err, io_data}, 0);
        sb.delete();
        pos = 0; cyc = 0; last_rise = -1; first = 1; in_wait = 0;
        err_case = ddr && (div == 0);
        vpct = pct;
        gen_left = nw;
        p = period(div);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;
        if (err_case) begin
            cycles(200);
            chk("R10 config error flag", cfg_err, 1);
            chk("R10 no transmit", io_en, 0);
            gen_left = 0;
            s_valid = 1'b0;
            return;
        end
        if (do_wait) begin
            cycles(10 * p + 5);
            io_wait = 1'b1;
            cycles(2 * p + 4);
            in_wait = 1;
            snap = io_data;
            cycles(6 * p);
            chk("R9 enable low while waiting", io_en, 0);
            chk("R9 data held while waiting", io_data, snap);
            in_wait = 0;
            io_wait = 1'b0;
        end
        t = 0;
        while ((gen_left > 0 || sb.size() != 0) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk("R7 all accepted words delivered", sb.size(), 0);
        cycles(3 * p + 2);
        chk("R6 idle enable low", {io_en, io_start}, 0);
        chk("R6 idle data holds last word", io_data, last_exp);
    endtask

    initial begin
        void'($urandom(32'd4242));
        // directed corners
        run_case(4'd0, 1'b0, 1'b0, 5'd16, 8'd3, 30, 100, 0); // fastest SDR
        run_case(4'd1, 1'b1, 1'b0, 5'd8,  8'd0, 30, 100, 0); // fastest DDR, one-word lines
        run_case(4'd3, 1'b0, 1'b1, 5'd12, 8'd4, 30, 70,  1); // rising launch with wait
        run_case(4'd0, 1'b1, 1'b0, 5'd16, 8'd2, 10, 100, 0); // illegal DDR setting
        run_case(4'd2, 1'b1, 1'b1, 5'd3,  8'd5, 25, 60,  1); // width below range
        run_case(4'd5, 1'b0, 1'b0, 5'd20, 8'd1, 20, 50,  0); // width above range
        // constrained random
        for (int i = 0; i < 8; i++) begin
            logic [3:0] d;
            logic dd;
            d  = 4'($urandom_range(7));
            dd = (d != 0) ? 1'($urandom_range(1)) : 1'b0;
            run_case(d, dd, 1'($urandom_range(1)), 5'($urandom_range(8, 16)),
                     8'($urandom_range(6)), 30, 40 + $urandom_range(60), 1'($urandom_range(1)));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule